// File: doc/BRIEF.md
# Distributed-Sample ATM Cell Scrambler and Descrambler

This block scrambles a byte-wide stream of 53-byte ATM cells on transmit and undoes the scrambling on receive. Both directions use a 31-stage generator with feedback polynomial x^31 + x^28 + 1. The generator is frame-synchronous, not self-synchronizing. It runs freely from reset and is never restarted at a cell boundary. On transmit, every byte except the header check byte (byte index 4) is XORed with the keystream. The header check is then computed over the four scrambled header bytes and placed in byte 4. Because the check covers the bytes as they appear on the line, a receiver can test it without descrambling anything first.

The receiver steps its own generator on every valid byte. It uses the header check to confirm that its cell framing and keystream agree with the transmitter. First it hunts for a cell whose upper six check bits match. It then requires a set number of consecutive cells whose full eight-bit check is correct before it declares lock. Once locked, it descrambles the cells. If too many consecutive alignment attempts fail, it falls back to unscrambled pass-through.

Each direction has its own enable. A separate self-synchronizing-mode input overrides both, so that this block passes data through unchanged whenever that mode is selected. A start-of-cell strobe marks byte 0 of each cell.

Top module: `dss_cell_scrambler`

## Requirements
- R1: Each direction has a generator with feedback polynomial x^31 + x^28 + 1 and seed all ones. The generator output is its bit 30, and the new bit 0 is bit 30 XOR bit 27. The generator steps eight times for each valid byte, and the first bit produced is the byte's MSB. It is never reset at a cell boundary, and its state does not depend on the enables.
- R2: When the transmit path is active (tx_en high, sss_en low), output bytes at every index other than 4 equal the input byte XOR the keystream byte.
- R3: When the transmit path is active, output byte 4 equals CRC-8 (generator x^8+x^2+x+1, initial value 0, MSB first) over scrambled output bytes 0 to 3, XOR 0x55.
- R4: When tx_en is low or sss_en is high, every transmit output byte equals its input byte.
- R5: Each output byte and its valid flag appear exactly one clock after the input byte is accepted. The byte index is 0 on a cycle where sof is high, and otherwise counts valid bytes after that cycle.
- R6: rx_status encodes 0 hunt, 1 verify, 2 locked and 3 fallback. In hunt, a received byte 4 whose bits 7:2 match the expected check of the raw header moves the state to verify and clears the failure count. A mismatch adds one failure.
- R7: In verify, each full eight-bit match adds one good cell, and LOCK_CELLS consecutive matches give locked. A mismatch returns the state to hunt and adds one failure.
- R8: After FAIL_CELLS consecutive failures the state becomes fallback. It remains in fallback while the receive path stays active.
- R9: In the locked state, receive bytes other than index 4 are XORed with the keystream. In every other state, and always at index 4, the receive bytes pass through unchanged.
- R10: When rx_en is low or sss_en is high, the receive path passes data through, the state is forced to hunt and both counts are cleared.
- R11: In the locked state, a byte 4 that fails the full eight-bit check returns the state to hunt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit scrambling enable |
| rx_en | input | 1 | Receive descrambling enable |
| sss_en | input | 1 | Self-synchronizing mode selected; overrides both enables |
| tx_valid | input | 1 | Transmit input byte valid |
| tx_sof | input | 1 | Transmit byte is cell byte 0 |
| tx_data | input | 8 | Transmit input byte |
| rx_valid | input | 1 | Receive input byte valid |
| rx_sof | input | 1 | Receive byte is cell byte 0 |
| rx_data | input | 8 | Receive input byte |
| tx_out_valid | output | 1 | Transmit output valid |
| tx_out_data | output | 8 | Scrambled transmit byte |
| rx_out_valid | output | 1 | Receive output valid |
| rx_out_data | output | 8 | Descrambled receive byte |
| rx_status | output | 2 | Receive lock state |

## Verification
The bench counts cells exactly at the lock and failure thresholds. A receiver that was off by one cell would report locked or fallback one cell early or late. Cells whose check byte is wrong only in its two low bits separate the six-bit hunt test from the eight-bit test. A design that used the wrong width in either state would stay in hunt or never leave verify. The bench checks that the generator keeps running across cells and through disabled stretches. A design that restarted it at each cell, or held it while disabled, would produce wrong scrambled bytes in the later cells. The bench also drives the self-synchronizing override while fallback is held. A design that ignored the override would keep scrambling, or would fail to clear fallback.

// File: rtl/dss_pkg.sv
package dss_pkg;
  localparam int CELL_BYTES = 53;
  localparam int HEC_IDX    = 4;
  localparam int GEN_LEN    = 31;
  localparam int TAP_A      = 30;
  localparam int TAP_B      = 27;
  localparam logic [7:0] HEC_COSET = 8'h55;
  localparam logic [7:0] CRC_POLY  = 8'h07;

  typedef enum logic [1:0] {
    RX_HUNT     = 2'd0,
    RX_VERIFY   = 2'd1,
    RX_LOCKED   = 2'd2,
    RX_FALLBACK = 2'd3
  } rx_state_e;

  // eight generator steps: {keystream byte MSB first, next state}
  function automatic logic [GEN_LEN+7:0] gen_step8(input logic [GEN_LEN-1:0] s);
    logic [7:0] k;
    logic [GEN_LEN-1:0] t;
    t = s;
    k = '0;
    for (int b = 7; b >= 0; b--) begin
      k[b] = t[TAP_A];
      t = {t[GEN_LEN-2:0], t[TAP_A] ^ t[TAP_B]};
    end
    return {k, t};
  endfunction

  // bit-serial CRC-8 update, MSB of the data first
  function automatic logic [7:0] crc8_byte(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/dss_keygen.sv
module dss_keygen
  import dss_pkg::*;
#(
  parameter logic [GEN_LEN-1:0] SEED = '1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output logic [7:0] ks
);
  logic [GEN_LEN-1:0] state;
  logic [GEN_LEN-1:0] nxt;

  always_comb begin
    {ks, nxt} = gen_step8(state);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= nxt;
  end
endmodule

// File: rtl/dss_tx.sv
module dss_tx
  import dss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [7:0] in_data,
  input  logic [7:0] ks,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       hec_slot
);
  localparam int IW = $clog2(CELL_BYTES);

  logic [IW-1:0] cnt;
  logic [IW-1:0] cur;
  logic [7:0]    scr;
  logic [7:0]    crc;

  assign cur      = in_sof ? '0 : cnt;
  assign scr      = in_data ^ ks;
  assign hec_slot = (cur == IW'(HEC_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      crc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cnt <= (cur == IW'(CELL_BYTES - 1)) ? cur : cur + IW'(1);
        if (cur < IW'(HEC_IDX))
          crc <= crc8_byte((cur == '0) ? 8'h00 : crc, scr);
        if (!active)       out_data <= in_data;
        else if (hec_slot) out_data <= crc ^ HEC_COSET;
        else               out_data <= scr;
      end
    end
  end
endmodule

// File: rtl/dss_rx.sv
module dss_rx
  import dss_pkg::*;
#(
  parameter int LOCK_CELLS = 6,
  parameter int FAIL_CELLS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [7:0] in_data,
  input  logic [7:0] ks,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic [1:0] status,
  output logic       hec_slot,
  output logic       m6,
  output logic       m8
);
  localparam int IW = $clog2(CELL_BYTES);
  localparam int GW = $clog2(LOCK_CELLS + 1);
  localparam int FW = $clog2(FAIL_CELLS + 1);

  logic [IW-1:0] cnt;
  logic [IW-1:0] cur;
  logic [7:0]    crc;
  logic [7:0]    exp_hec;
  logic [GW-1:0] good;
  logic [FW-1:0] fail;
  rx_state_e     st;
  logic          judge;
  logic          fail_out;
  logic          lock_in;

  assign cur      = in_sof ? '0 : cnt;
  assign hec_slot = (cur == IW'(HEC_IDX));
  assign exp_hec  = crc ^ HEC_COSET;
  assign m6       = (in_data[7:2] == exp_hec[7:2]);
  assign m8       = (in_data == exp_hec);
  assign judge    = active && in_valid && hec_slot;
  assign fail_out = ((32'(fail) + 32'd1) >= FAIL_CELLS);
  assign lock_in  = ((32'(good) + 32'd1) >= LOCK_CELLS);
  assign status   = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      crc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cnt <= (cur == IW'(CELL_BYTES - 1)) ? cur : cur + IW'(1);
        if (cur < IW'(HEC_IDX))
          crc <= crc8_byte((cur == '0) ? 8'h00 : crc, in_data);
        if (active && st == RX_LOCKED && !hec_slot) out_data <= in_data ^ ks;
        else                                         out_data <= in_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      st   <= RX_HUNT;
      good <= '0;
      fail <= '0;
    end else if (judge) begin
      unique case (st)
        RX_HUNT: begin
          if (m6) begin
            st   <= RX_VERIFY;
            good <= '0;
            fail <= '0;
          end else if (fail_out) begin
            st <= RX_FALLBACK;
          end else begin
            fail <= fail + FW'(1);
          end
        end
        RX_VERIFY: begin
          if (m8) begin
            if (lock_in) begin
              st   <= RX_LOCKED;
              fail <= '0;
            end else begin
              good <= good + GW'(1);
            end
          end else if (fail_out) begin
            st <= RX_FALLBACK;
          end else begin
            st   <= RX_HUNT;
            fail <= fail + FW'(1);
          end
        end
        RX_LOCKED: begin
          if (!m8) st <= RX_HUNT;
        end
        default: st <= RX_FALLBACK;
      endcase
    end
  end
endmodule

// File: rtl/dss_cell_scrambler.sv
module dss_cell_scrambler
  import dss_pkg::*;
#(
  parameter int LOCK_CELLS = 6,
  parameter int FAIL_CELLS = 8,
  parameter logic [GEN_LEN-1:0] SEED = '1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic       sss_en,
  input  logic       tx_valid,
  input  logic       tx_sof,
  input  logic [7:0] tx_data,
  input  logic       rx_valid,
  input  logic       rx_sof,
  input  logic [7:0] rx_data,
  output logic       tx_out_valid,
  output logic [7:0] tx_out_data,
  output logic       rx_out_valid,
  output logic [7:0] rx_out_data,
  output logic [1:0] rx_status
);
  logic [7:0] tx_ks;
  logic [7:0] rx_ks;
  logic       tx_act;
  logic       rx_act;
  logic       tx_hec_slot;
  logic       rx_hec_slot;
  logic       rx_m6;
  logic       rx_m8;

  assign tx_act = tx_en && !sss_en;
  assign rx_act = rx_en && !sss_en;

  dss_keygen #(.SEED(SEED)) u_tx_gen (
    .clk(clk), .rst_n(rst_n), .adv(tx_valid), .ks(tx_ks)
  );

  dss_keygen #(.SEED(SEED)) u_rx_gen (
    .clk(clk), .rst_n(rst_n), .adv(rx_valid), .ks(rx_ks)
  );

  dss_tx u_tx (
    .clk(clk), .rst_n(rst_n), .active(tx_act),
    .in_valid(tx_valid), .in_sof(tx_sof), .in_data(tx_data), .ks(tx_ks),
    .out_valid(tx_out_valid), .out_data(tx_out_data), .hec_slot(tx_hec_slot)
  );

  dss_rx #(.LOCK_CELLS(LOCK_CELLS), .FAIL_CELLS(FAIL_CELLS)) u_rx (
    .clk(clk), .rst_n(rst_n), .active(rx_act),
    .in_valid(rx_valid), .in_sof(rx_sof), .in_data(rx_data), .ks(rx_ks),
    .out_valid(rx_out_valid), .out_data(rx_out_data), .status(rx_status),
    .hec_slot(rx_hec_slot), .m6(rx_m6), .m8(rx_m8)
  );
endmodule

// File: rtl/dss_chk.sv
module dss_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       rx_en,
  input logic       sss_en,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       tx_out_valid,
  input logic [7:0] tx_out_data,
  input logic [7:0] rx_out_data,
  input logic [1:0] rx_status,
  input logic       rx_hec_slot,
  input logic       rx_m8
);
  // R4
  tx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && (!tx_en || sss_en)) |=> tx_out_data == $past(tx_data));

  // R5
  tx_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> tx_out_valid);

  // R5
  tx_idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |=> !tx_out_valid);

  // R8
  fallback_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_status == 2'd3 && rx_en && !sss_en) |=> rx_status == 2'd3);

  // R7
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_status != 2'd2) ##1 (rx_status == 2'd2) |->
      ($past(rx_status) == 2'd1 && $past(rx_valid && rx_hec_slot && rx_m8)));

  // R10
  rx_off_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en || sss_en) |=> rx_status == 2'd0);

  // R9
  rx_hec_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_hec_slot) |=> rx_out_data == $past(rx_data));
endmodule

bind dss_cell_scrambler dss_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .sss_en(sss_en),
  .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
  .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .rx_out_data(rx_out_data),
  .rx_status(rx_status), .rx_hec_slot(rx_hec_slot), .rx_m8(rx_m8)
);

// File: tb/sim_dss_cell_scrambler.sv
module sim_dss_cell_scrambler;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, tx_en, rx_en, sss_en;
  logic       tx_valid, tx_sof, rx_valid, rx_sof;
  logic [7:0] tx_data, rx_data;
  logic       tx_out_valid, rx_out_valid;
  logic [7:0] tx_out_data, rx_out_data;
  logic [1:0] rx_status;

  dss_cell_scrambler #(.LOCK_CELLS(3), .FAIL_CELLS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .sss_en(sss_en),
    .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
    .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
    .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data), .rx_status(rx_status)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // entry: {tx_en, rx_en, sss_en, hec_err[1:0], seed[7:0], expected status after cell[1:0]}
  // hec_err: 0 correct, 1 low two bits flipped, 2 all bits flipped
  localparam int NV = 15;
  localparam logic [14:0] VEC [NV] = '{
    {3'b110, 2'd0, 8'h10, 2'd1},  // R6 six-bit match leaves hunt
    {3'b110, 2'd0, 8'h21, 2'd1},  // R7 good 1 of 3
    {3'b110, 2'd0, 8'h32, 2'd1},  // R7 good 2 of 3
    {3'b110, 2'd0, 8'h43, 2'd2},  // R7 third good cell locks
    {3'b110, 2'd0, 8'h54, 2'd2},  // R9 payload descrambled
    {3'b110, 2'd1, 8'h65, 2'd0},  // R11 eight-bit miss drops lock
    {3'b110, 2'd1, 8'h76, 2'd1},  // R6 six-bit test ignores low bits
    {3'b110, 2'd1, 8'h87, 2'd0},  // R7 verify needs all eight, failure 1
    {3'b110, 2'd2, 8'h98, 2'd0},  // R6 failure 2
    {3'b110, 2'd2, 8'hA9, 2'd0},  // R6 failure 3
    {3'b110, 2'd2, 8'hBA, 2'd3},  // R8 failure 4 gives fallback
    {3'b110, 2'd0, 8'hCB, 2'd3},  // R8 fallback held, pass-through
    {3'b111, 2'd0, 8'hDC, 2'd0},  // R4 R10 override clears and passes
    {3'b000, 2'd0, 8'hED, 2'd0},  // R4 R10 both disabled
    {3'b110, 2'd0, 8'hFE, 2'd1}   // R1 generator kept running throughout
  };

  logic [30:0] g;
  logic [1:0]  prev_st;

  function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    repeat (8) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic next_ks(output logic [7:0] k);
    for (int b = 0; b < 8; b++) begin
      k[7-b] = g[30];
      g = {g[29:0], g[30] ^ g[27]};
    end
  endtask

  task automatic drive(input logic [7:0] td, input logic [7:0] rd, input bit first);
    tx_valid = 1'b1; rx_valid = 1'b1;
    tx_sof = first;  rx_sof = first;
    tx_data = td;    rx_data = rd;
  endtask

  task automatic run_cell(input int n, input logic [14:0] v);
    logic [7:0] pl [53];
    logic [7:0] kb [53];
    logic [7:0] sc [53];
    logic [7:0] ri [53];
    logic [7:0] c, etx, erx, atx, arx;
    logic [1:0] exp_st, st_i;
    bit txa, rxa, tx_bad, rx_bad, vbad;
    int ftx, frx;
    txa = v[14] && !v[12];
    rxa = v[13] && !v[12];
    exp_st = v[1:0];
    for (int i = 0; i < 53; i++) begin
      pl[i] = v[9:2] + 8'(i * 7);
      next_ks(kb[i]);
      sc[i] = pl[i] ^ kb[i];
    end
    c = 8'h00;
    for (int i = 0; i < 4; i++) c = crc_b(c, sc[i]);
    sc[4] = c ^ 8'h55;
    for (int i = 0; i < 53; i++) ri[i] = sc[i];
    ri[4] = sc[4] ^ ((v[11:10] == 2'd1) ? 8'h03 : (v[11:10] == 2'd2) ? 8'hFF : 8'h00);
    tx_en = v[14]; rx_en = v[13]; sss_en = v[12];
    tx_bad = 0; rx_bad = 0; vbad = 0; ftx = 0; frx = 0;
    etx = 0; erx = 0; atx = 0; arx = 0;
    drive(pl[0], ri[0], 1'b1);
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      if (!tx_out_valid || !rx_out_valid) vbad = 1;
      if (tx_out_data !== (txa ? sc[i] : pl[i]) && !tx_bad) begin
        tx_bad = 1; ftx = i; atx = tx_out_data; etx = txa ? sc[i] : pl[i];
      end
      st_i = (i <= 4) ? prev_st : exp_st;
      if (rx_out_data !== ((rxa && st_i == 2'd2 && i != 4) ? pl[i] : ri[i]) && !rx_bad) begin
        rx_bad = 1; frx = i; arx = rx_out_data;
        erx = (rxa && st_i == 2'd2 && i != 4) ? pl[i] : ri[i];
      end
      if (i < 52) drive(pl[i+1], ri[i+1], 1'b0);
    end
    // R1 R2 R3 R4 R5: transmit bytes and valid timing
    checks++;
    if (tx_bad || vbad) begin
      fails++;
      $display("FAIL R1/R2/R3/R4/R5 cell %0d byte %0d: actual %02h expected %02h (valid ok=%0b)",
               n, ftx, atx, etx, !vbad);
    end
    // R9 R10: receive bytes
    checks++;
    if (rx_bad) begin
      fails++;
      $display("FAIL R9/R10 cell %0d byte %0d: actual %02h expected %02h", n, frx, arx, erx);
    end
    // R6 R7 R8 R11: status after cell
    checks++;
    if (rx_status !== exp_st) begin
      fails++;
      $display("FAIL R6/R7/R8/R11 cell %0d status: actual %0d expected %0d", n, rx_status, exp_st);
    end
    prev_st = exp_st;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    g = '1;
    prev_st = 2'd0;
    rst_n = 1'b0; tx_en = 1'b0; rx_en = 1'b0; sss_en = 1'b0;
    tx_valid = 1'b0; rx_valid = 1'b0; tx_sof = 1'b0; rx_sof = 1'b0;
    tx_data = '0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state: hunt, no output valid
    checks++;
    if (rx_status !== 2'd0 || tx_out_valid !== 1'b0 || rx_out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset: actual st=%0d tv=%0b rv=%0b expected 0 0 0",
               rx_status, tx_out_valid, rx_out_valid);
    end
    for (int n = 0; n < NV; n++) run_cell(n, VEC[n]);
    tx_valid = 1'b0; rx_valid = 1'b0;
    @(negedge clk);
    // R5 idle input gives no output valid
    checks++;
    if (tx_out_valid !== 1'b0 || rx_out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R5 idle: actual tv=%0b rv=%0b expected 0 0", tx_out_valid, rx_out_valid);
    end
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule